// File: doc/BRIEF.md
# Indirect Configuration Cycle Generator

This unit sits in a host bridge between the processor and a downstream bus engine. Software selects a target by writing a 32-bit selector word into an address register. It then reads or writes a data window, and the unit turns that access into one configuration transaction. The address phase carries the correct format for a device on the local bus or for a bus behind a bridge.

Both processor ports are decoded over wide aliased ranges. The selector register answers anywhere in 0xFEC0_0000..0xFEDF_FFFF. The data window answers anywhere in 0xFEE0_0000..0xFEEF_FFFF. Inside the selector word, bit 31 is the enable, [23:16] is the bus number, [15:11] the device, [10:8] the function and [7:2] the register. For a local-bus target, the device number becomes a one-hot select line in the upper address bits. The processor side uses a hold-until-ready handshake. The downstream side uses a request that is held until acknowledged.

Processor byte lanes follow the size code and the low address bits. Write data is already lane-aligned on the processor bus.

Top module: `cfg_access_bridge`

## Requirements
- R1: Any address in 0xFEC0_0000..0xFEDF_FFFF reaches the selector register. Writes update only the enabled byte lanes. Reads return the stored bits 31 and 23:2, with bits 30:24 and 1:0 as zero. No downstream request is made.
- R2: When enable is set and the device is not 31, a data-window access (0xFEE0_0000..0xFEEF_FFFF) produces exactly one downstream request. It carries cfgWrite equal to the processor direction and the processor write data.
- R3: A data-window access with enable clear, device 31, or a local-bus device with no select line makes no request. A read returns 0xFFFF_FFFF and a write is discarded.
- R4: Bus number 0 gives a local-bus cycle. cfgAddr[1:0]=00, cfgAddr[10:8] is the function, cfgAddr[7:2] is the register, and exactly bit 11+device is set among bits 31:11. With the default of 21 select lines, devices 21..30 have no line.
- R5: A nonzero bus number gives a bridged cycle: cfgAddr = {8'h00, bus, device, function, register, 2'b01}.
- R6: Byte enables come from cpuSize and cpuAddr[1:0]. Size 0 (byte) enables lane addr[1:0]. Size 1 (half) enables 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1. Sizes 2 and 3 enable 4'b1111.
- R7: cfgReq and all request fields stay stable until cfgAck. cpuReady rises in the cycle after the ack. A read then returns the cfgRdata that came with the ack.
- R8: An address outside both windows makes no request. A read returns zero and a write changes nothing.
- R9: After reset, cpuReady and cfgReq are low and the selector register reads zero.
- R10: cpuReady is a single-cycle pulse and never coincides with cfgReq. An access that needs no downstream cycle is answered one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuValid | input | 1 | Processor access pending, held until cpuReady |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Processor byte address |
| cpuSize | input | 2 | 0 byte, 1 half, 2/3 word |
| cpuWdata | input | 32 | Lane-aligned write data |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Read data, valid with cpuReady |
| cfgReq | output | 1 | Configuration request to bus engine |
| cfgWrite | output | 1 | Request direction |
| cfgAddr | output | 32 | Address-phase value |
| cfgByteEn | output | 4 | Byte lane enables |
| cfgWdata | output | 32 | Write data for the cycle |
| cfgAck | input | 1 | One-cycle completion from bus engine |
| cfgRdata | input | 32 | Read data, valid with cfgAck |

## Verification
A corrupted selector register shows up on the very next data-window access. The request lands on the wrong select line or the wrong bus, or a cycle appears or disappears where ones were expected, and a read-back of the selector shows it directly. A stuck controller state shows within a cycle or two of the next access: a missing or doubled ready pulse, a request that drops before its ack, or a request that never ends. Wrong decode limits show at the first access to a range edge, as a read value of zero, all ones or register contents where another was due.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned SEL_LSB  = 11;
  localparam logic [31:0] SEL_KEEP = 32'h80FF_FFFC;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } ctrlState_e;

  typedef struct packed {
    logic loadSel;
    logic launch;
    logic takeSel;
    logic takeOnes;
    logic takeZero;
    logic takeBus;
  } ctrlStrobe_t;

  function automatic logic [LANES-1:0] laneMask(input logic [1:0] lowAddr,
                                                input logic [1:0] size);
    logic [LANES-1:0] m;
    unique case (size)
      2'd0:    m = 4'b0001 << lowAddr;
      2'd1:    m = lowAddr[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cfg_bridge_dp.sv
module cfg_bridge_dp
  import cfg_bridge_pkg::*;
#(
  parameter logic [31:0] SEL_WIN_BASE  = 32'hFEC0_0000,
  parameter int unsigned SEL_WIN_BITS  = 21,
  parameter logic [31:0] DATA_WIN_BASE = 32'hFEE0_0000,
  parameter int unsigned DATA_WIN_BITS = 20,
  parameter int unsigned NUM_SEL_LINES = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              cpuWrite,
  input  logic [31:0]       cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] cfgRdata,
  output logic              hitSelPort,
  output logic              hitDataPort,
  output logic              cycleOk,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cfgWrite,
  output logic [31:0]       cfgAddr,
  output logic [LANES-1:0]  cfgByteEn,
  output logic [DATA_W-1:0] cfgWdata
);

  localparam logic [31:0] SEL_WIN_MASK  = ~((32'h1 << SEL_WIN_BITS) - 32'h1);
  localparam logic [31:0] DATA_WIN_MASK = ~((32'h1 << DATA_WIN_BITS) - 32'h1);
  localparam int unsigned DEV_W = 5;
  localparam logic [DEV_W-1:0] DEV_NONE = '1;

  logic [31:0]      selReg;
  logic [LANES-1:0] curLanes;
  logic             selEnable;
  logic [7:0]       busNum;
  logic [DEV_W-1:0] devNum;
  logic [2:0]       funcNum;
  logic [5:0]       regNum;
  logic [31:0]      lineWord;
  logic             devHasLine;
  logic [31:0]      localAddr;
  logic [31:0]      bridgedAddr;

  assign hitSelPort  = (cpuAddr & SEL_WIN_MASK)  == (SEL_WIN_BASE & SEL_WIN_MASK);
  assign hitDataPort = (cpuAddr & DATA_WIN_MASK) == (DATA_WIN_BASE & DATA_WIN_MASK);
  assign curLanes    = laneMask(cpuAddr[1:0], cpuSize);

  assign selEnable = selReg[31];
  assign busNum    = selReg[23:16];
  assign devNum    = selReg[15:11];
  assign funcNum   = selReg[10:8];
  assign regNum    = selReg[7:2];

  // One select line per device number that has one.
  for (genvar g = 0; g < 32; g++) begin : gLine
    if (g >= SEL_LSB && g < SEL_LSB + NUM_SEL_LINES) begin : gUsed
      assign lineWord[g] = (devNum == DEV_W'(g - SEL_LSB));
    end else begin : gFree
      assign lineWord[g] = 1'b0;
    end
  end

  assign devHasLine  = |lineWord;
  assign localAddr   = lineWord | {21'b0, funcNum, regNum, 2'b00};
  assign bridgedAddr = {8'h00, busNum, devNum, funcNum, regNum, 2'b01};
  assign cycleOk     = selEnable && (devNum != DEV_NONE) &&
                       ((busNum != 8'h00) || devHasLine);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
    end else if (strobe.loadSel) begin
      for (int i = 0; i < LANES; i++) begin
        if (curLanes[i]) selReg[8*i +: 8] <= cpuWdata[8*i +: 8] & SEL_KEEP[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAddr   <= '0;
      cfgByteEn <= '0;
      cfgWdata  <= '0;
      cfgWrite  <= 1'b0;
    end else if (strobe.launch) begin
      cfgAddr   <= (busNum == 8'h00) ? localAddr : bridgedAddr;
      cfgByteEn <= curLanes;
      cfgWdata  <= cpuWdata;
      cfgWrite  <= cpuWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRdata <= '0;
    end else begin
      unique case (1'b1)
        strobe.takeSel:  cpuRdata <= selReg;
        strobe.takeOnes: cpuRdata <= '1;
        strobe.takeZero: cpuRdata <= '0;
        strobe.takeBus:  cpuRdata <= cfgRdata;
        default:         cpuRdata <= cpuRdata;
      endcase
    end
  end

endmodule

// File: rtl/cfg_bridge_ctrl.sv
module cfg_bridge_ctrl
  import cfg_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuValid,
  input  logic        cpuWrite,
  input  logic        hitSelPort,
  input  logic        hitDataPort,
  input  logic        cycleOk,
  input  logic        cfgAck,
  output ctrlStrobe_t strobe,
  output logic        cfgReq,
  output logic        cpuReady
);

  ctrlState_e state;
  ctrlState_e stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cpuValid) begin
          if (hitSelPort) begin
            strobe.loadSel = cpuWrite;
            strobe.takeSel = 1'b1;
            stateNext      = ST_RESP;
          end else if (hitDataPort && cycleOk) begin
            strobe.launch  = 1'b1;
            stateNext      = ST_BUS;
          end else if (hitDataPort) begin
            strobe.takeOnes = 1'b1;
            stateNext       = ST_RESP;
          end else begin
            strobe.takeZero = 1'b1;
            stateNext       = ST_RESP;
          end
        end
      end
      ST_BUS: begin
        if (cfgAck) begin
          strobe.takeBus = 1'b1;
          stateNext      = ST_RESP;
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cfgReq   = (state == ST_BUS);
  assign cpuReady = (state == ST_RESP);

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cfg_bridge_pkg::*;
#(
  parameter logic [31:0] SEL_WIN_BASE  = 32'hFEC0_0000,
  parameter int unsigned SEL_WIN_BITS  = 21,
  parameter logic [31:0] DATA_WIN_BASE = 32'hFEE0_0000,
  parameter int unsigned DATA_WIN_BITS = 20,
  parameter int unsigned NUM_SEL_LINES = 21
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuValid,
  input  logic        cpuWrite,
  input  logic [31:0] cpuAddr,
  input  logic [1:0]  cpuSize,
  input  logic [31:0] cpuWdata,
  output logic        cpuReady,
  output logic [31:0] cpuRdata,
  output logic        cfgReq,
  output logic        cfgWrite,
  output logic [31:0] cfgAddr,
  output logic [3:0]  cfgByteEn,
  output logic [31:0] cfgWdata,
  input  logic        cfgAck,
  input  logic [31:0] cfgRdata
);

  ctrlStrobe_t strobe;
  logic        hitSelPort;
  logic        hitDataPort;
  logic        cycleOk;

  cfg_bridge_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuValid    (cpuValid),
    .cpuWrite    (cpuWrite),
    .hitSelPort  (hitSelPort),
    .hitDataPort (hitDataPort),
    .cycleOk     (cycleOk),
    .cfgAck      (cfgAck),
    .strobe      (strobe),
    .cfgReq      (cfgReq),
    .cpuReady    (cpuReady)
  );

  cfg_bridge_dp #(
    .SEL_WIN_BASE  (SEL_WIN_BASE),
    .SEL_WIN_BITS  (SEL_WIN_BITS),
    .DATA_WIN_BASE (DATA_WIN_BASE),
    .DATA_WIN_BITS (DATA_WIN_BITS),
    .NUM_SEL_LINES (NUM_SEL_LINES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cpuWrite    (cpuWrite),
    .cpuAddr     (cpuAddr),
    .cpuSize     (cpuSize),
    .cpuWdata    (cpuWdata),
    .cfgRdata    (cfgRdata),
    .hitSelPort  (hitSelPort),
    .hitDataPort (hitDataPort),
    .cycleOk     (cycleOk),
    .cpuRdata    (cpuRdata),
    .cfgWrite    (cfgWrite),
    .cfgAddr     (cfgAddr),
    .cfgByteEn   (cfgByteEn),
    .cfgWdata    (cfgWdata)
  );

endmodule

// File: rtl/cfg_access_bridge_chk.sv
module cfg_access_bridge_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cpuReady,
  input logic        cfgReq,
  input logic        cfgAck,
  input logic        cfgWrite,
  input logic [31:0] cfgAddr,
  input logic [3:0]  cfgByteEn,
  input logic [31:0] cfgWdata
);

  // R7: request and its fields held until acknowledged
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && !cfgAck |=> cfgReq && $stable(cfgAddr) && $stable(cfgByteEn)
                          && $stable(cfgWdata) && $stable(cfgWrite));

  // R4: local-bus cycle drives exactly one select line
  a_r4_one_line: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && cfgAddr[1:0] == 2'b00 |-> $countones(cfgAddr[31:11]) == 1);

  // R5: only the two address formats appear, bridged form has a nonzero bus
  a_r5_format: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> cfgAddr[1] == 1'b0 &&
               (!cfgAddr[0] || (cfgAddr[31:24] == 8'h00 && cfgAddr[23:16] != 8'h00)));

  // R6: a launched cycle always has at least one lane
  a_r6_lanes: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> cfgByteEn != 4'b0000);

  // R10: ready is a single pulse and never overlaps a request
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !cfgReq);

endmodule

bind cfg_access_bridge cfg_access_bridge_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuReady  (cpuReady),
  .cfgReq    (cfgReq),
  .cfgAck    (cfgAck),
  .cfgWrite  (cfgWrite),
  .cfgAddr   (cfgAddr),
  .cfgByteEn (cfgByteEn),
  .cfgWdata  (cfgWdata)
);

// File: tb/cfg_access_bridge_bench.sv
module cfg_access_bridge_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0;
  logic        cpuWrite = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [1:0]  cpuSize = 2'd2;
  logic [31:0] cpuWdata = '0;
  logic        cpuReady;
  logic [31:0] cpuRdata;
  logic        cfgReq;
  logic        cfgWrite;
  logic [31:0] cfgAddr;
  logic [3:0]  cfgByteEn;
  logic [31:0] cfgWdata;
  logic        cfgAck = 1'b0;
  logic [31:0] cfgRdata = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // observations of the last access
  logic [31:0] gotRdata;
  int          gotReqs;
  logic [31:0] gotAddr;
  logic [3:0]  gotBe;
  logic [31:0] gotWdata;
  logic        gotWrite;
  logic        gotUnstable;
  int          gotLat;

  logic [31:0] selModel = '0;

  localparam logic [31:0] SEL_BASE  = 32'hFEC0_0000;
  localparam logic [31:0] DATA_BASE = 32'hFEE0_0000;

  cfg_access_bridge u_cfg_access_bridge (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuSize(cpuSize), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata), .cfgReq(cfgReq),
    .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn),
    .cfgWdata(cfgWdata), .cfgAck(cfgAck), .cfgRdata(cfgRdata)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] busModel(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [3:0] expLanes(input logic [1:0] lo, input logic [1:0] sz);
    if (sz == 2'd0) return 4'b0001 << lo;
    if (sz == 2'd1) return lo[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] selWord(input bit en, input int bus, input int dev,
                                          input int fn, input int rg);
    return (en ? 32'h8000_0000 : 32'h0) | (32'(bus) << 16) | (32'(dev) << 11) |
           (32'(fn) << 8) | (32'(rg) << 2);
  endfunction

  // one processor access with a responding bus engine
  task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int ackDelay);
    int waitCnt = 0;
    int guard = 0;
    gotReqs = 0; gotUnstable = 1'b0; gotLat = 0;
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuSize = sz; cpuWdata = wd;
    forever begin
      @(negedge clk);
      gotLat++;
      cfgAck = 1'b0;
      if (cpuReady) begin
        gotRdata = cpuRdata;
        break;
      end
      if (cfgReq) begin
        if (gotReqs == 0) begin
          gotAddr = cfgAddr; gotBe = cfgByteEn; gotWdata = cfgWdata; gotWrite = cfgWrite;
          gotReqs = 1;
        end else if (gotAddr != cfgAddr || gotBe != cfgByteEn ||
                     gotWdata != cfgWdata || gotWrite != cfgWrite) begin
          gotUnstable = 1'b1;
        end
        if (waitCnt == ackDelay) begin
          cfgAck = 1'b1;
          cfgRdata = busModel(cfgAddr);
        end
        waitCnt++;
      end
      guard++;
      if (guard > 100) begin
        gotRdata = 'x;
        break;
      end
    end
    cpuValid = 1'b0;
  endtask

  task automatic writeSel(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
    logic [3:0] ln;
    ln = expLanes(a[1:0], sz);
    for (int i = 0; i < 4; i++)
      if (ln[i]) selModel[8*i +: 8] = wd[8*i +: 8] & (32'h80FF_FFFC >> (8*i));
    access(1'b1, a, sz, wd, 0);
    check(gotReqs == 0 && gotLat == 1, "R1 selector write no cycle", gotReqs, 0);
  endtask

  task automatic readSel(input logic [31:0] a);
    access(1'b0, a, 2'd2, 32'h0, 0);
    check(gotRdata === selModel, "R1 selector readback", gotRdata, selModel);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(cpuReady === 1'b0, "R9 ready low in reset", cpuReady, 0);
    check(cfgReq === 1'b0, "R9 req low in reset", cfgReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuReady === 1'b0 && cfgReq === 1'b0, "R9 idle after reset",
          {cpuReady, cfgReq}, 0);
    access(1'b0, SEL_BASE, 2'd2, 0, 0);
    check(gotRdata === 32'h0, "R9 selector zero after reset", gotRdata, 0);

    // R1 window edges, masking and byte lanes
    writeSel(SEL_BASE, 2'd2, 32'hFFFF_FFFF);
    readSel(32'hFEDF_FFFC);
    writeSel(32'hFEC0_0001, 2'd0, 32'h0000_0000);
    readSel(32'hFED1_2340);
    writeSel(32'hFEC0_0CFA, 2'd1, 32'h1234_0000);
    readSel(SEL_BASE);
    writeSel(32'hFEC0_0CF8, 2'd2, 32'h0000_0000);
    readSel(32'hFEC0_0CF8);

    // R8 outside both windows
    access(1'b0, 32'hFEBF_FFFC, 2'd2, 0, 0);
    check(gotRdata === 32'h0 && gotReqs == 0, "R8 below windows reads zero", gotRdata, 0);
    access(1'b0, 32'hFEF0_0000, 2'd2, 0, 0);
    check(gotRdata === 32'h0 && gotReqs == 0, "R8 above data window reads zero", gotRdata, 0);
    writeSel(SEL_BASE, 2'd2, selWord(1, 0, 4, 1, 3));
    access(1'b1, 32'hFEBF_FFFC, 2'd2, 32'hFFFF_FFFF, 0);
    check(gotReqs == 0 && gotLat == 1, "R8 outside write no cycle", gotReqs, 0);
    readSel(SEL_BASE);

    // R4 / R3 local-bus sweep over every device number
    for (int dev = 0; dev < 32; dev++) begin
      logic [31:0] expA;
      int fn;
      int rg;
      fn = dev % 8;
      rg = (dev * 5) % 64;
      writeSel(SEL_BASE + 32'(dev * 8), 2'd2, selWord(1, 0, dev, fn, rg));
      access(1'b0, DATA_BASE + 32'(dev << 12), 2'd2, 0, dev % 3);
      if (dev <= 20) begin
        expA = (32'h1 << (11 + dev)) | (32'(fn) << 8) | (32'(rg) << 2);
        check(gotReqs == 1 && gotAddr === expA, "R4 local address phase", gotAddr, expA);
        check(gotRdata === busModel(expA), "R7 read data returned", gotRdata, busModel(expA));
        check(!gotUnstable && gotLat == (dev % 3) + 2, "R7 hold and ready timing",
              32'(gotLat), 32'((dev % 3) + 2));
        check(gotBe === 4'hF && gotWrite === 1'b0, "R2 read request fields", {gotWrite, gotBe}, 5'h0F);
      end else begin
        check(gotReqs == 0 && gotRdata === 32'hFFFF_FFFF, "R3 no line reads ones",
              gotRdata, 32'hFFFF_FFFF);
        check(gotLat == 1, "R10 no-cycle answer latency", 32'(gotLat), 1);
      end
    end

    // R5 bridged format, R3 device 31
    for (int b = 0; b < 3; b++) begin
      int bus;
      bus = (b == 0) ? 1 : ((b == 1) ? 7 : 255);
      for (int k = 0; k < 4; k++) begin
        int dev;
        logic [31:0] expA;
        dev = (k == 0) ? 0 : ((k == 1) ? 21 : ((k == 2) ? 30 : 31));
        writeSel(SEL_BASE, 2'd2, selWord(1, bus, dev, k + 2, 63 - k));
        access(1'b0, 32'hFEE0_0CFC, 2'd2, 0, k);
        expA = {8'h00, 8'(bus), 5'(dev), 3'(k + 2), 6'(63 - k), 2'b01};
        if (dev != 31) begin
          check(gotReqs == 1 && gotAddr === expA, "R5 bridged address phase", gotAddr, expA);
          check(gotRdata === busModel(expA), "R7 bridged read data", gotRdata, busModel(expA));
        end else begin
          check(gotReqs == 0 && gotRdata === 32'hFFFF_FFFF, "R3 device 31 reads ones",
                gotRdata, 32'hFFFF_FFFF);
        end
      end
    end

    // R3 enable clear: read ones, write dropped
    writeSel(SEL_BASE, 2'd2, selWord(0, 0, 3, 0, 1));
    access(1'b0, DATA_BASE, 2'd2, 0, 0);
    check(gotReqs == 0 && gotRdata === 32'hFFFF_FFFF, "R3 disabled read ones", gotRdata, 32'hFFFF_FFFF);
    access(1'b1, DATA_BASE, 2'd2, 32'h1111_2222, 0);
    check(gotReqs == 0 && gotLat == 1, "R3 disabled write dropped", gotReqs, 0);

    // R6 / R2 lanes for every size and offset on writes
    writeSel(SEL_BASE, 2'd2, selWord(1, 0, 2, 5, 9));
    for (int sz = 0; sz < 4; sz++) begin
      for (int lo = 0; lo < 4; lo++) begin
        logic [31:0] wd;
        logic [3:0]  expBe;
        wd = 32'hC0DE_0000 | 32'(sz * 16 + lo);
        expBe = expLanes(2'(lo), 2'(sz));
        access(1'b1, 32'hFEEF_FFF0 | 32'(lo), 2'(sz), wd, lo);
        check(gotReqs == 1 && gotBe === expBe, "R6 byte enables", gotBe, expBe);
        check(gotWrite === 1'b1 && gotWdata === wd, "R2 write request fields", gotWdata, wd);
      end
    end

    repeat (2) @(negedge clk);
    check(cfgReq === 1'b0 && cpuReady === 1'b0, "R10 quiet after traffic", {cfgReq, cpuReady}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule